// File: doc/BRIEF.md
# Phase-Shifted Multicarrier PWM Modulator

This block turns one digital reference level into on/off commands for a chain of identical half-bridge cells that are stacked in series to form one converter arm. Each cell is given its own triangular carrier. All carriers come from one shared up/down phase counter, and each cell's carrier is offset from that counter by a fixed fraction of a period. A cell's command is 1, which means its upper switch is on and its capacitor voltage appears at the output, while the held reference is above that cell's carrier. It is 0, with the lower switch on and zero output, when the reference is not above the carrier. The arm voltage is the sum of the cell outputs. It therefore lies between zero and N_CELLS times the cell voltage and never goes negative.

The reference is sampled once per carrier period, at the peak of cell 0's carrier. It is held until the next peak, so that each command switches at most twice per period. The arm-select input makes the block serve a lower arm. In that mode the level held is the full-scale level minus the reference, so over each period an upper and a lower arm driven from the same sample together deliver the full DC level. The block also outputs the number of cells that are on, registered together with the commands, for a downstream cell selector. The parameter REF_SIGNED selects an offset-binary reading of a signed reference, in which zero maps to mid-scale. The parameter PRESCALE slows the carrier, so that a fast clock can reach a carrier of a few kHz.

Top module: `psc_modulator`

## Requirements
- R1: One clock after each rising edge, cmd_o[k] equals 1 exactly when the held level is strictly greater than the carrier value of cell k at that edge. Otherwise it equals 0.
- R2: With PRESCALE=1, a master phase p counts 0 to 2^(REF_W+1)-1 and wraps. Cell k uses phase (p + k*2^(REF_W+1)/N_CELLS) mod 2^(REF_W+1). Its carrier is that phase q when q < 2^REF_W, and 2^(REF_W+1)-1-q otherwise.
- R3: The held level changes only at the edge where the master phase equals 2^REF_W-1. A reference change between two such edges has no effect on cmd_o until the commands that follow that edge.
- R4: The level taken at the sampling edge is min(ref_i, 2^REF_W) when low_arm_i=0, and 2^REF_W minus that value when low_arm_i=1. Over one full period on a fixed level r, the sum of on_cnt_o is N_CELLS*2r. The upper and lower sums for one reference therefore add up to N_CELLS*2^(REF_W+1).
- R5: While en_i is low at an edge, every cmd_o bit and on_cnt_o read 0 after that edge.
- R6: on_cnt_o always equals the number of 1 bits in cmd_o.
- R7: A reference at or above 2^REF_W turns every cell on for the whole period in the upper arm and turns every cell off in the lower arm. A reference of 0 keeps every upper-arm cell off.
- R8: After a synchronous reset, cmd_o and on_cnt_o are 0, the held level is 0 and the master phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Modulator enable; low forces all commands off |
| low_arm_i | input | 1 | 1 = lower arm, the reference is complemented against full scale |
| ref_i | input | REF_W+1 | Reference level in carrier units, offset-binary when REF_SIGNED=1 |
| cmd_o | output | N_CELLS | Registered per-cell on/off commands |
| on_cnt_o | output | $clog2(N_CELLS+1) | Registered number of cells that are on |

## Verification
The embedded assertions check on every cycle that the on-count matches the command bits and that the commands are silent after a disabled cycle. They also check that the held level moves only on the sampling strobe and never exceeds full scale, and that the master phase wraps and halts correctly. They cannot show that each cell compares against the correctly shifted triangle, that the complement keeps the upper and lower arms summing to full scale over a period, or that a reference change mid-period is deferred. The bench shows these by comparing every cycle against a behavioural model that has its own phase and held level, and by summing the on-count over aligned carrier periods.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Which arm of a phase leg this modulator serves.
  typedef enum logic {
    ARM_UPPER = 1'b0,
    ARM_LOWER = 1'b1
  } arm_side_e;

endpackage

// File: rtl/psc_carrier_gen.sv
module psc_carrier_gen #(
  parameter int N_CELLS  = 8,
  parameter int REF_W    = 6,
  parameter int PRESCALE = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  output logic [N_CELLS-1:0][REF_W-1:0]   tri_o,
  output logic                            peak_o
);

  localparam int PH_W  = REF_W + 1;
  localparam int SPAN  = 2 ** PH_W;
  localparam int HALF  = 2 ** REF_W;
  localparam int STEP  = SPAN / N_CELLS;
  localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic            tick;
  logic [PH_W-1:0] ph_q;

  // Optional clock prescaler to stretch the carrier period.
  generate
    if (PRESCALE > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
        end else if (div_q == DIV_W'(PRESCALE - 1)) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      assign tick = (div_q == DIV_W'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  // Master phase: one up/down triangle period spans SPAN ticks.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else if (tick) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // Sampling strobe at the top of cell 0's triangle.
  assign peak_o = tick && (ph_q == PH_W'(HALF - 1));

  // Per-cell phase offset and fold into a triangle.
  generate
    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
      localparam logic [PH_W-1:0] OFFSET = PH_W'(k * STEP);
      logic [PH_W-1:0] ph_k;
      assign ph_k     = ph_q + OFFSET;
      assign tri_o[k] = ph_k[PH_W-1] ? ~ph_k[REF_W-1:0] : ph_k[REF_W-1:0];
    end
  endgenerate

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && ph_q == PH_W'(SPAN - 1)) |=> (ph_q == '0)); // R2

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ph_q)); // R2

  AST_PEAK_TOP: assert property (@(posedge clk) disable iff (rst)
    peak_o |-> (tri_o[0] == REF_W'(HALF - 1))); // R2

endmodule

// File: rtl/psc_ref_hold.sv
module psc_ref_hold
  import psc_pkg::*;
#(
  parameter int REF_W      = 6,
  parameter bit REF_SIGNED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             peak_i,
  input  logic             low_arm_i,
  input  logic [REF_W:0]   ref_i,
  output logic [REF_W:0]   level_o
);

  localparam int HALF = 2 ** REF_W;
  localparam int EW   = REF_W + 3;

  logic signed [EW-1:0] ext;
  logic        [REF_W:0] sat;
  logic        [REF_W:0] level_d;
  logic        [REF_W:0] level_q;
  arm_side_e             side;

  // Reference interpretation chosen by parameter.
  generate
    if (REF_SIGNED) begin : g_signed
      assign ext = $signed({{2{ref_i[REF_W]}}, ref_i}) + $signed(EW'(HALF / 2));
    end else begin : g_unsigned
      assign ext = $signed({2'b00, ref_i});
    end
  endgenerate

  // Clamp to the carrier span [0, HALF].
  always_comb begin
    if (ext < 0) begin
      sat = '0;
    end else if (ext > $signed(EW'(HALF))) begin
      sat = (REF_W + 1)'(HALF);
    end else begin
      sat = ext[REF_W:0];
    end
  end

  assign side    = arm_side_e'(low_arm_i);
  assign level_d = (side == ARM_LOWER) ? ((REF_W + 1)'(HALF) - sat) : sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else if (peak_i) begin
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !peak_i |=> $stable(level_q)); // R3

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    level_q <= (REF_W + 1)'(HALF)); // R7

endmodule

// File: rtl/psc_cell_compare.sv
module psc_cell_compare #(
  parameter int N_CELLS = 8,
  parameter int REF_W   = 6,
  parameter int CNT_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en_i,
  input  logic [REF_W:0]                 level_i,
  input  logic [N_CELLS-1:0][REF_W-1:0]  tri_i,
  output logic [N_CELLS-1:0]             cmd_o,
  output logic [CNT_W-1:0]               cnt_o
);

  logic [N_CELLS-1:0] cmp;
  logic [CNT_W-1:0]   cnt_d;
  logic [N_CELLS-1:0] cmd_q;
  logic [CNT_W-1:0]   cnt_q;

  generate
    for (genvar k = 0; k < N_CELLS; k++) begin : g_cmp
      assign cmp[k] = (level_i > {1'b0, tri_i[k]});
    end
  endgenerate

  always_comb begin
    cnt_d = '0;
    for (int k = 0; k < N_CELLS; k++) begin
      cnt_d = cnt_d + CNT_W'(cmp[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      cmd_q <= cmp;
      cnt_q <= cnt_d;
    end else begin
      cmd_q <= '0;
      cnt_q <= '0;
    end
  end

  assign cmd_o = cmd_q;
  assign cnt_o = cnt_q;

  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CNT_W'($countones(cmd_q))); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cmd_q == '0 && cnt_q == '0)); // R5

endmodule

// File: rtl/psc_modulator.sv
module psc_modulator #(
  parameter int N_CELLS    = 8,
  parameter int REF_W      = 6,
  parameter int PRESCALE   = 1,
  parameter bit REF_SIGNED = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               en_i,
  input  logic                               low_arm_i,
  input  logic [REF_W:0]                     ref_i,
  output logic [N_CELLS-1:0]                 cmd_o,
  output logic [$clog2(N_CELLS+1)-1:0]       on_cnt_o
);

  localparam int CNT_W = $clog2(N_CELLS + 1);

  logic [N_CELLS-1:0][REF_W-1:0] tri_w;
  logic                          peak_w;
  logic [REF_W:0]                level_w;

  psc_carrier_gen #(
    .N_CELLS (N_CELLS),
    .REF_W   (REF_W),
    .PRESCALE(PRESCALE)
  ) carrier_i (
    .clk   (clk),
    .rst   (rst),
    .tri_o (tri_w),
    .peak_o(peak_w)
  );

  psc_ref_hold #(
    .REF_W     (REF_W),
    .REF_SIGNED(REF_SIGNED)
  ) hold_i (
    .clk      (clk),
    .rst      (rst),
    .peak_i   (peak_w),
    .low_arm_i(low_arm_i),
    .ref_i    (ref_i),
    .level_o  (level_w)
  );

  psc_cell_compare #(
    .N_CELLS(N_CELLS),
    .REF_W  (REF_W),
    .CNT_W  (CNT_W)
  ) compare_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .level_i(level_w),
    .tri_i  (tri_w),
    .cmd_o  (cmd_o),
    .cnt_o  (on_cnt_o)
  );

  AST_CMD_NO_STUCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!en_i || level_w == '0) |=> (cmd_o == '0)); // R1

endmodule

// File: tb/psc_modulator_tb_top.sv
module psc_modulator_tb_top;

  localparam int N    = 8;
  localparam int RW   = 6;
  localparam int HALF = 2 ** RW;
  localparam int SPAN = 2 * HALF;
  localparam int STEP = SPAN / N;
  localparam int CW   = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          low_arm = 1'b0;
  logic [RW:0]   ref_v = '0;
  logic [N-1:0]  cmd;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit started = 1'b0;
  string cur_req = "R8";

  // Behavioural model state
  int m_ph = 0;
  int m_lvl = 0;
  int last_ph = 0;
  logic [N-1:0] exp_cmd = '0;
  int exp_cnt = 0;

  always #2 clk = ~clk;

  psc_modulator dut_i (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en),
    .low_arm_i(low_arm),
    .ref_i    (ref_v),
    .cmd_o    (cmd),
    .on_cnt_o (cnt)
  );

  always @(posedge clk) begin
    started = 1'b1;
    cyc = cyc + 1;
    if (rst) begin
      m_ph = 0; m_lvl = 0; exp_cmd = '0; exp_cnt = 0; last_ph = 0;
    end else begin
      exp_cnt = 0;
      for (int k = 0; k < N; k++) begin
        int q; int t;
        q = (m_ph + k * STEP) % SPAN;
        t = (q < HALF) ? q : (SPAN - 1 - q);
        exp_cmd[k] = en && (m_lvl > t);
        if (exp_cmd[k]) exp_cnt++;
      end
      last_ph = m_ph;
      if (m_ph == HALF - 1) begin
        int s;
        s = (int'(ref_v) > HALF) ? HALF : int'(ref_v);
        m_lvl = low_arm ? (HALF - s) : s;
      end
      m_ph = (m_ph + 1) % SPAN;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Per-cycle comparison with the model, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      check(cur_req, cmd == exp_cmd, int'(cmd), int'(exp_cmd), "cmd vs model");
      check("R6", int'(cnt) == $countones(cmd), int'(cnt), $countones(cmd), "count vs bits");
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sum on-count over one aligned period on a settled held level.
  task automatic period_sum(output int s);
    s = 0;
    do @(negedge clk); while (last_ph != HALF - 1);
    for (int i = 0; i < SPAN; i++) begin
      @(negedge clk);
      s += int'(cnt);
    end
  endtask

  initial begin
    int su; int sl;
    cycles(4);
    cur_req = "R8";
    check("R8", cmd == '0, int'(cmd), 0, "reset cmd");
    check("R8", cnt == '0, int'(cnt), 0, "reset count");
    rst = 1'b0;
    cycles(10);
    cur_req = "R5";
    check("R5", cmd == '0 && cnt == '0, int'(cnt), 0, "disabled at start");

    // Main function and carrier shifts
    cur_req = "R1";
    en = 1'b1; ref_v = 7'd20;
    cycles(300);
    cur_req = "R2";
    ref_v = 7'd1;
    cycles(300);
    cur_req = "R1";
    ref_v = 7'd45;
    cycles(260);

    // Mid-period reference changes are deferred to the sampling edge
    cur_req = "R3";
    ref_v = 7'd50; cycles(37);
    ref_v = 7'd10; cycles(53);
    ref_v = 7'd33; cycles(11);
    ref_v = 7'd60; cycles(200);

    // Upper/lower complement over a full period
    cur_req = "R4";
    ref_v = 7'd24; low_arm = 1'b0;
    period_sum(su); period_sum(su);
    check("R4", su == N * 2 * 24, su, N * 2 * 24, "upper period sum");
    low_arm = 1'b1;
    period_sum(sl); period_sum(sl);
    check("R4", sl == N * 2 * (HALF - 24), sl, N * 2 * (HALF - 24), "lower period sum");
    check("R4", su + sl == N * SPAN, su + sl, N * SPAN, "arm sum full scale");
    low_arm = 1'b0;

    // Enable low mid-run
    cur_req = "R5";
    ref_v = 7'd40; cycles(150);
    en = 1'b0; cycles(2);
    check("R5", cmd == '0, int'(cmd), 0, "cmd while disabled");
    check("R5", cnt == '0, int'(cnt), 0, "count while disabled");
    cycles(100);
    en = 1'b1; cycles(50);

    // Saturation and zero
    cur_req = "R7";
    ref_v = 7'd100; cycles(SPAN * 2 + 3);
    check("R7", cmd == '1, int'(cmd), (1 << N) - 1, "saturated upper all on");
    check("R7", int'(cnt) == N, int'(cnt), N, "saturated count");
    low_arm = 1'b1; cycles(SPAN * 2 + 3);
    check("R7", cmd == '0, int'(cmd), 0, "saturated lower all off");
    low_arm = 1'b0; ref_v = 7'd0; cycles(SPAN * 2 + 3);
    check("R7", cmd == '0 && cnt == '0, int'(cnt), 0, "zero reference all off");
    cycles(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule